// File: doc/BRIEF.md
# PCI Interrupt Line Steering Router

This block sits between four shared, active-low, level-triggered PCI interrupt lines and the sixteen request inputs of a legacy interrupt controller. Each PCI line has its own 8-bit steering register. The register either parks the line, which then has no effect, or sends it to one of eleven legacy IRQ numbers. The raw ISA request lines enter the block, and the block emits the final 16-bit request vector that goes to the controller.

Any IRQ that one or more enabled PCI lines target takes its level from those lines alone, and its ISA source is suppressed. Lines that share an IRQ combine as a wired-OR. The steering registers are written and read through a byte-wide configuration port. The controller's trigger-mode register is outside this block, and every steered IRQ is taken to be in level mode.

Top module: `pirq_steer`

## Requirements
- R1: After reset, each steering register reads 8'h80, so every line is parked, and `irq_out` equals `isa_irq` on all sixteen bits.
- R2: A write with `cfg_wr` high at address 8'h60+i (i=0..3, line A..D) stores `cfg_wdata` into register i at the clock edge. A write to any other address changes no register. `cfg_rdata` returns the full stored byte of the register addressed by `cfg_addr`, and returns 8'h00 for any other address.
- R3: A line whose register has bit 7 = 1 neither drives nor masks any IRQ.
- R4: With bit 7 = 0, bits 3:0 name the target IRQ by number. Codes 3–7 select IRQ3–IRQ7, codes 9–12 select IRQ9–IRQ12, and codes 14 and 15 select IRQ14 and IRQ15.
- R5: Codes 0, 1, 2, 8 and 13 are reserved. With bit 7 = 0, such a code neither drives nor masks any IRQ.
- R6: `pirq_n` is active low. A steered IRQ output is 1 exactly when at least one line steered to it has its `pirq_n` bit at 0.
- R7: Any number of lines may target the same IRQ at once, and their requests are OR-combined.
- R8: While at least one enabled line targets an IRQ, the `isa_irq` bit of that IRQ has no effect on `irq_out`.
- R9: `irq_out` bits 0, 1, 2, 8 and 13 always equal the matching `isa_irq` bits.
- R10: Register bits 6:4 are stored and read back, but they do not affect steering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data for the addressed steering register |
| pirq_n | input | 4 | PCI interrupt lines A..D, active low |
| isa_irq | input | 16 | Raw legacy ISA requests, one per IRQ number |
| irq_out | output | 16 | Final request vector to the interrupt controller |

## Verification
The assertions treat `pirq_n` and `isa_irq` as levels that are settled by each clock edge. The output path is combinational, so the properties sample it only at edges. They also assume that a write's address and data are stable across the edge that stores them. The stimulus meets both assumptions by changing every input just after a rising edge. It holds inputs steady through the falling edge, where the output is compared against the model.

// File: rtl/pirq_steer_pkg.sv
package pirq_steer_pkg;

  localparam int IRQ_W  = 16;
  localparam int CODE_W = 4;
  localparam int CFG_W  = 8;

  // Bit 7 of a steering byte parks the line; bits 3:0 carry the IRQ number.
  localparam int PARK_BIT = 7;

  // Returns a one-hot (or zero) target vector for one steering byte.
  function automatic logic [IRQ_W-1:0] route_target(
    input logic [CFG_W-1:0] cfg,
    input logic [IRQ_W-1:0] valid_mask
  );
    logic [CODE_W-1:0] code;
    logic [IRQ_W-1:0]  tgt;
    code = cfg[CODE_W-1:0];
    tgt  = '0;
    if (!cfg[PARK_BIT] && valid_mask[code])
      tgt[code] = 1'b1;
    return tgt;
  endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_steer_pkg::*;
#(
  parameter int               NUM_LINES = 4,
  parameter logic [CFG_W-1:0] BASE_ADDR = 8'h60,
  parameter logic [CFG_W-1:0] RESET_VAL = 8'h80
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_wr,
  input  logic [CFG_W-1:0]               cfg_addr,
  input  logic [CFG_W-1:0]               cfg_wdata,
  output logic [CFG_W-1:0]               cfg_rdata,
  output logic [NUM_LINES-1:0][CFG_W-1:0] route_q
);

  logic [NUM_LINES-1:0] addr_hit;
  logic [NUM_LINES-1:0] wr_hit;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_reg
    localparam logic [CFG_W-1:0] ADDR_I = CFG_W'(BASE_ADDR + i);

    assign addr_hit[i] = (cfg_addr == ADDR_I);
    assign wr_hit[i]   = cfg_wr && addr_hit[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         route_q[i] <= RESET_VAL;
      else if (wr_hit[i]) route_q[i] <= cfg_wdata;
    end

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> route_q[i] == $past(cfg_wdata));

    // R2
    no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[i] |=> $stable(route_q[i]));
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (addr_hit[i]) cfg_rdata = route_q[i];
  end

  // R2
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_hit));

endmodule

// File: rtl/pirq_route_decode.sv
module pirq_route_decode
  import pirq_steer_pkg::*;
#(
  parameter int               NUM_LINES  = 4,
  parameter logic [IRQ_W-1:0] VALID_MASK = 16'hDEF8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LINES-1:0][CFG_W-1:0] route_q,
  input  logic [NUM_LINES-1:0]            pirq_n,
  output logic [NUM_LINES-1:0][IRQ_W-1:0] line_sel,
  output logic [NUM_LINES-1:0]            line_active
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign line_sel[i]    = route_target(route_q[i], VALID_MASK);
    assign line_active[i] = ~pirq_n[i];

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(line_sel[i]));

    // R3
    parked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      route_q[i][PARK_BIT] |-> line_sel[i] == '0);

    // R5
    reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !VALID_MASK[route_q[i][CODE_W-1:0]] |-> line_sel[i] == '0);
  end

endmodule

// File: rtl/pirq_irq_merge.sv
module pirq_irq_merge
  import pirq_steer_pkg::*;
#(
  parameter int               NUM_LINES  = 4,
  parameter logic [IRQ_W-1:0] VALID_MASK = 16'hDEF8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LINES-1:0][IRQ_W-1:0] line_sel,
  input  logic [NUM_LINES-1:0]            line_active,
  input  logic [IRQ_W-1:0]                isa_irq,
  output logic [IRQ_W-1:0]                irq_out
);

  logic [IRQ_W-1:0] route_mask;
  logic [IRQ_W-1:0] route_drive;

  always_comb begin
    route_mask  = '0;
    route_drive = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      route_mask  = route_mask | line_sel[i];
      route_drive = route_drive | (line_sel[i] & {IRQ_W{line_active[i]}});
    end
  end

  assign irq_out = (isa_irq & ~route_mask) | route_drive;

  for (genvar n = 0; n < IRQ_W; n++) begin : g_irq
    if (!VALID_MASK[n]) begin : g_fixed
      // R9
      legacy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[n] == isa_irq[n]);
    end else begin : g_steer
      // R8
      masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_mask[n] && !route_drive[n]) |-> !irq_out[n]);
      // R6
      drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_drive[n] |-> irq_out[n]);
    end
  end

endmodule

// File: rtl/pirq_steer.sv
module pirq_steer
  import pirq_steer_pkg::*;
#(
  parameter int               NUM_LINES  = 4,
  parameter logic [7:0]       BASE_ADDR  = 8'h60,
  parameter logic [7:0]       RESET_VAL  = 8'h80,
  parameter logic [15:0]      VALID_MASK = 16'hDEF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [7:0]           cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  input  logic [NUM_LINES-1:0] pirq_n,
  input  logic [15:0]          isa_irq,
  output logic [15:0]          irq_out
);

  logic [NUM_LINES-1:0][CFG_W-1:0] route_q;
  logic [NUM_LINES-1:0][IRQ_W-1:0] line_sel;
  logic [NUM_LINES-1:0]            line_active;

  pirq_route_regs #(
    .NUM_LINES(NUM_LINES), .BASE_ADDR(BASE_ADDR), .RESET_VAL(RESET_VAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .route_q(route_q)
  );

  pirq_route_decode #(
    .NUM_LINES(NUM_LINES), .VALID_MASK(VALID_MASK)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .route_q(route_q), .pirq_n(pirq_n),
    .line_sel(line_sel), .line_active(line_active)
  );

  pirq_irq_merge #(
    .NUM_LINES(NUM_LINES), .VALID_MASK(VALID_MASK)
  ) u_merge (
    .clk(clk), .rst_n(rst_n), .line_sel(line_sel), .line_active(line_active),
    .isa_irq(isa_irq), .irq_out(irq_out)
  );

endmodule

// File: tb/pirq_steer_tb.sv
module pirq_steer_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [3:0]  pirq_n = 4'hF;
  logic [15:0] isa_irq = 16'h0000;
  logic [15:0] irq_out;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  logic [7:0] m_reg [4];

  pirq_steer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pirq_n(pirq_n),
    .isa_irq(isa_irq), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // IRQ numbers a steering code may select (R4); all others are reserved (R5).
  function automatic bit code_is_irq(int c);
    return c inside {3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15};
  endfunction

  function automatic logic [15:0] model_out();
    logic [15:0] r;
    for (int n = 0; n < 16; n++) begin
      bit taken = 0;
      bit level = 0;
      for (int i = 0; i < 4; i++) begin
        if (m_reg[i][7] == 1'b0 && code_is_irq(int'(m_reg[i][3:0]))
            && int'(m_reg[i][3:0]) == n) begin
          taken = 1;
          if (pirq_n[i] == 1'b0) level = 1;
        end
      end
      r[n] = taken ? level : isa_irq[n];
    end
    return r;
  endfunction

  function automatic logic [7:0] model_rd();
    if (cfg_addr >= 8'h60 && cfg_addr <= 8'h63) return m_reg[cfg_addr - 8'h60];
    return 8'h00;
  endfunction

  // Reference register state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_reg[i] = 8'h80;
    end else if (cfg_wr && cfg_addr >= 8'h60 && cfg_addr <= 8'h63) begin
      m_reg[cfg_addr - 8'h60] = cfg_wdata;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [15:0] eo;
      logic [7:0]  er;
      eo = model_out();
      er = model_rd();
      checks++;
      if (irq_out !== eo) begin
        errors++;
        $display("FAIL %s irq_out actual=%h expected=%h", cur_req, irq_out, eo);
      end
      checks++;
      if (cfg_rdata !== er) begin
        errors++;
        $display("FAIL %s cfg_rdata actual=%h expected=%h", cur_req, cfg_rdata, er);
      end
    end
  end

  task automatic step(input bit wr, input logic [7:0] a, input logic [7:0] d,
                      input logic [3:0] p, input logic [15:0] isa);
    @(posedge clk);
    #2;
    cfg_wr = wr; cfg_addr = a; cfg_wdata = d; pirq_n = p; isa_irq = isa;
  endtask

  task automatic wr_reg(input int line, input logic [7:0] d);
    step(1, 8'(8'h60 + line), d, pirq_n, isa_irq);
    step(0, 8'(8'h60 + line), 8'h00, pirq_n, isa_irq);
  endtask

  task automatic check_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    isa_irq = 16'hA5C3;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state, all lines parked, pass-through
    cur_req = "R1";
    for (int i = 0; i < 4; i++) begin
      step(0, 8'(8'h60 + i), 8'h00, 4'h0, 16'h5A3C);
      @(negedge clk);
      check_eq("R1 reset read", {8'h00, cfg_rdata}, 16'h0080);
    end
    @(negedge clk);
    check_eq("R1 pass-through", irq_out, 16'h5A3C);

    // R2: write/readback, reserved bits 6:4 kept, stray addresses ignored
    cur_req = "R2";
    wr_reg(0, 8'hF5); wr_reg(1, 8'h86); wr_reg(2, 8'hC9); wr_reg(3, 8'hFF);
    step(1, 8'h64, 8'h03, 4'hF, 16'h0);
    step(1, 8'h5F, 8'h04, 4'hF, 16'h0);
    step(0, 8'h62, 8'h00, 4'hF, 16'h0);
    @(negedge clk);
    check_eq("R2 readback line C", {8'h00, cfg_rdata}, 16'h00C9);
    step(0, 8'h64, 8'h00, 4'hF, 16'h0);
    @(negedge clk);
    check_eq("R2 unmapped read", {8'h00, cfg_rdata}, 16'h0000);

    // R4/R5: sweep every code on line A, others parked
    for (int i = 1; i < 4; i++) wr_reg(i, 8'h80);
    for (int c = 0; c < 16; c++) begin
      cur_req = code_is_irq(c) ? "R4" : "R5";
      wr_reg(0, 8'(c));
      step(0, 8'h60, 8'h00, 4'hE, 16'hFFFF);
      step(0, 8'h60, 8'h00, 4'hF, 16'hFFFF);
      @(negedge clk);
      if (code_is_irq(c))
        check_eq("R4 routed idle line masks isa", {15'h0, irq_out[c]}, 16'h0000);
      else
        check_eq("R5 reserved code leaves isa", irq_out, 16'hFFFF);
      step(0, 8'h60, 8'h00, 4'hE, 16'h0000);
    end

    // R3: parked line with a valid code
    cur_req = "R3";
    wr_reg(0, 8'h8B);
    step(0, 8'h60, 8'h00, 4'h0, 16'h0800);
    @(negedge clk);
    check_eq("R3 parked line passes isa", irq_out, 16'h0800);

    // R10: bits 6:4 do not matter
    cur_req = "R10";
    wr_reg(0, 8'h7A);
    step(0, 8'h60, 8'h00, 4'hE, 16'h0000);
    @(negedge clk);
    check_eq("R10 reserved bits ignored", irq_out, 16'h0400);

    // R6/R7: all four lines on IRQ11, each alone and together
    cur_req = "R7";
    for (int i = 0; i < 4; i++) wr_reg(i, 8'h0B);
    for (int p = 0; p < 16; p++) begin
      step(0, 8'h61, 8'h00, 4'(p), 16'hFFFF);
      @(negedge clk);
      check_eq("R6 R7 shared irq11", {15'h0, irq_out[11]}, (p == 15) ? 16'h0 : 16'h1);
    end

    // R8: masked isa source on steered IRQs
    cur_req = "R8";
    wr_reg(0, 8'h03); wr_reg(1, 8'h0F); wr_reg(2, 8'h09); wr_reg(3, 8'h06);
    step(0, 8'h60, 8'h00, 4'hF, 16'hFFFF);
    @(negedge clk);
    check_eq("R8 masked sources", irq_out, 16'hFFFF & ~16'h8248);

    // R9: fixed legacy positions
    cur_req = "R9";
    step(0, 8'h60, 8'h00, 4'h0, 16'h2107);
    @(negedge clk);
    check_eq("R9 fixed positions", irq_out & 16'h2107, 16'h2107);

    // R6: random mix, compared each cycle against the model
    cur_req = "R6";
    for (int k = 0; k < 600; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if ($urandom_range(0, 3) == 0) d[7] = 1'b1; else d[7] = 1'b0;
      step($urandom_range(0, 2) == 0, 8'(8'h5E + $urandom_range(0, 7)), d,
           4'($urandom), 16'($urandom));
    end
    step(0, 8'h00, 8'h00, 4'hF, 16'h0);
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule